// File: doc/BRIEF.md
# Looped Static Schedule Controller

This block sequences a fixed, repeating firing schedule onto a small pool of processing units. A frame counter runs from zero to a configured frame length minus one and wraps. One-off firings are released when the frame counter equals their configured start time. Repeated firings are grouped into loops. Each loop is launched at a configured frame count, runs an inner phase counter of a configured period, and issues a fixed number of firings, one per period.

Every firing belongs to a numbered user. One-off firings are users 0 to NS-1 and loops are users NS to NS+NL-1. Each user is mapped by parameter onto a processing unit, so several graph nodes can share one unit or be spread across several units. For every unit the controller drives a start pulse and an input-mux select. For every user it drives an output-buffer latch enable at the end of each firing. For loops it also gives the iteration index, which names the token slot being written. The processing units and the buffers are outside the block.

Top module: `sched_loop_ctrl`

## Requirements
- R1: While reset is held low and in the cycle after its release, `top_count` is 0, every `loop_busy` bit is 0 and every `res_sel` field is 0.
- R2: `top_count` goes up by one on each clock and wraps from FRAME_LEN-1 to 0.
- R3: `sg_start[s]` is high exactly in the cycles where `top_count` equals SG_START[s].
- R4: `loop_go[l]` is high exactly when `top_count` equals LP_START[l]. `loop_busy[l]` is high from that cycle on for LP_COUNT[l]*LP_PERIOD[l] cycles.
- R5: `loop_fire[l]` pulses in the `loop_go` cycle and then every LP_PERIOD[l] cycles while the loop is busy. This gives LP_COUNT[l] pulses in total.
- R6: While `loop_busy[l]` is high, the field `loop_iter[l*IW +: IW]` holds the zero-based index of the current period. It goes up by one at each firing after the first.
- R7: `out_latch[s]` of a one-off user pulses at `top_count` = SG_START[s]+SG_DUR[s]-1. `out_latch[NS+l]` pulses in phase LP_DUR[l]-1 of every period of loop l.
- R8: `res_start[r]` is high exactly when at least one user mapped to unit r fires in that cycle. One-off users are numbered 0..NS-1 and loop users NS+l.
- R9: The field `res_sel[r*UW +: UW]` shows the number of the user that starts on unit r in that cycle. If several users start, it shows the highest-numbered one. In cycles without a start on unit r, it keeps its previous value.
- R10: A loop with a period of 1 fires in every busy cycle. A loop with a count of 1 fires once. Users that share a unit alternate its select in schedule order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| top_count | output | CW | Frame counter |
| sg_start | output | NS | Start pulse of each one-off firing |
| loop_go | output | NL | Launch pulse of each loop |
| loop_busy | output | NL | Loop in progress |
| loop_fire | output | NL | Start pulse of each loop firing |
| loop_iter | output | NL*IW | Iteration index per loop |
| out_latch | output | NS+NL | Output-buffer latch enable per user |
| res_start | output | NR | Start pulse per processing unit |
| res_sel | output | NR*UW | Input-mux select per processing unit, as a user number |

## Verification
A wrong phase or iteration register in a loop shows up at once. It moves `loop_fire`, `out_latch` or `loop_iter` in the same cycle the register goes wrong, and it shortens or lengthens `loop_busy` by the end of that loop. A stuck or lost select register shows on `res_sel` in the first cycle without a start on that unit. A frame counter fault moves every start pulse. Because the outputs are compared against an independent timing model on every clock, any of these faults is reported within one cycle of becoming visible. The bench runs a second configuration with period 1, count 1 and shared one-off users to reach the edge cases.

// File: rtl/sched_loop_ctrl.sv
module sched_loop_ctrl #(
  parameter int FRAME_LEN  = 34,
  parameter int NS         = 2,
  parameter int NL         = 2,
  parameter int NR         = 3,
  parameter int MAX_PERIOD = 16,
  parameter int MAX_COUNT  = 16,
  parameter int SG_RES    [NS] = '{0, 1},
  parameter int SG_START  [NS] = '{0, 17},
  parameter int SG_DUR    [NS] = '{1, 1},
  parameter int LP_RES    [NL] = '{2, 2},
  parameter int LP_START  [NL] = '{1, 18},
  parameter int LP_COUNT  [NL] = '{8, 8},
  parameter int LP_PERIOD [NL] = '{2, 2},
  parameter int LP_DUR    [NL] = '{2, 2},
  localparam int CW = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1,
  localparam int PW = (MAX_PERIOD > 1) ? $clog2(MAX_PERIOD) : 1,
  localparam int IW = (MAX_COUNT > 1) ? $clog2(MAX_COUNT) : 1,
  localparam int NU = NS + NL,
  localparam int UW = (NU > 1) ? $clog2(NU) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CW-1:0]    top_count,
  output logic [NS-1:0]    sg_start,
  output logic [NL-1:0]    loop_go,
  output logic [NL-1:0]    loop_busy,
  output logic [NL-1:0]    loop_fire,
  output logic [NL*IW-1:0] loop_iter,
  output logic [NU-1:0]    out_latch,
  output logic [NR-1:0]    res_start,
  output logic [NR*UW-1:0] res_sel
);

  function automatic int user_res(input int u);
    if (u < NS) return SG_RES[u];
    return LP_RES[u-NS];
  endfunction

  logic [CW-1:0] top_q;
  logic [NU-1:0] ustart;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) top_q <= '0;
    else        top_q <= (top_q == CW'(FRAME_LEN-1)) ? '0 : top_q + 1'b1;

  assign top_count = top_q;

  for (genvar s = 0; s < NS; s++) begin : g_sg
    assign sg_start[s]  = (top_q == CW'(SG_START[s]));
    assign out_latch[s] = (top_q == CW'(SG_START[s] + SG_DUR[s] - 1));
  end

  for (genvar l = 0; l < NL; l++) begin : g_lp
    logic          busy_q, go, act, ph_end, it_end;
    logic [PW-1:0] ph_q, ph;
    logic [IW-1:0] it_q, it;

    assign go     = (top_q == CW'(LP_START[l]));
    assign act    = go | busy_q;
    assign ph     = go ? '0 : ph_q;
    assign it     = go ? '0 : it_q;
    assign ph_end = (ph == PW'(LP_PERIOD[l] - 1));
    assign it_end = (it == IW'(LP_COUNT[l] - 1));

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        busy_q <= 1'b0;
        ph_q   <= '0;
        it_q   <= '0;
      end else if (act) begin
        if (ph_end) begin
          ph_q <= '0;
          if (it_end) busy_q <= 1'b0;
          else begin
            busy_q <= 1'b1;
            it_q   <= it + 1'b1;
          end
        end else begin
          ph_q   <= ph + 1'b1;
          it_q   <= it;
          busy_q <= 1'b1;
        end
      end

    assign loop_go[l]             = go;
    assign loop_busy[l]           = act;
    assign loop_fire[l]           = act && (ph == '0);
    assign loop_iter[l*IW +: IW]  = it;
    assign out_latch[NS+l]        = act && (ph == PW'(LP_DUR[l] - 1));
  end

  assign ustart = {loop_fire, sg_start};

  for (genvar r = 0; r < NR; r++) begin : g_res
    logic [NU-1:0] hv;
    logic          hit;
    logic [UW-1:0] idx, sel_q;

    for (genvar u = 0; u < NU; u++) begin : g_u
      assign hv[u] = ustart[u] && (user_res(u) == r);
    end

    always_comb begin
      hit = 1'b0;
      idx = sel_q;
      for (int u = 0; u < NU; u++)
        if (hv[u]) begin
          hit = 1'b1;
          idx = UW'(u);
        end
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sel_q <= '0;
      else        sel_q <= idx;

    assign res_start[r]         = hit;
    assign res_sel[r*UW +: UW]  = idx;
  end

endmodule

// File: rtl/sched_loop_ctrl_chk.sv
module sched_loop_ctrl_chk #(
  parameter int FRAME_LEN  = 34,
  parameter int NS         = 2,
  parameter int NL         = 2,
  parameter int NR         = 3,
  parameter int MAX_PERIOD = 16,
  parameter int MAX_COUNT  = 16,
  parameter int LP_RES [NL] = '{2, 2},
  localparam int CW = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1,
  localparam int IW = (MAX_COUNT > 1) ? $clog2(MAX_COUNT) : 1,
  localparam int NU = NS + NL,
  localparam int UW = (NU > 1) ? $clog2(NU) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CW-1:0]    top_count,
  input logic [NS-1:0]    sg_start,
  input logic [NL-1:0]    loop_go,
  input logic [NL-1:0]    loop_busy,
  input logic [NL-1:0]    loop_fire,
  input logic [NL*IW-1:0] loop_iter,
  input logic [NU-1:0]    out_latch,
  input logic [NR-1:0]    res_start,
  input logic [NR*UW-1:0] res_sel
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  // R2
  top_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    top_count == CW'(FRAME_LEN-1) |=> top_count == '0);

  // R2
  top_step_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    top_count != CW'(FRAME_LEN-1) |=> top_count == $past(top_count) + 1'b1);

  for (genvar l = 0; l < NL; l++) begin : g_lp
    // R4
    busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      loop_busy[l] && !loop_go[l] |-> $past(loop_busy[l]));

    // R5
    go_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      loop_go[l] |-> loop_fire[l]);

    // R6
    iter_step_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      loop_fire[l] && !loop_go[l] |-> loop_iter[l*IW +: IW] == $past(loop_iter[l*IW +: IW]) + 1'b1);

    // R7
    latch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_latch[NS+l] |-> loop_busy[l]);

    // R8
    fire_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
      loop_fire[l] |-> res_start[LP_RES[l]]);
  end

  for (genvar r = 0; r < NR; r++) begin : g_res
    // R9
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      !res_start[r] |-> res_sel[r*UW +: UW] == $past(res_sel[r*UW +: UW]));
  end

endmodule

bind sched_loop_ctrl sched_loop_ctrl_chk #(
  .FRAME_LEN(FRAME_LEN), .NS(NS), .NL(NL), .NR(NR),
  .MAX_PERIOD(MAX_PERIOD), .MAX_COUNT(MAX_COUNT), .LP_RES(LP_RES)
) u_chk (.*);

// File: tb/sched_loop_ctrl_tb.sv
module sched_loop_ctrl_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5ns clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  localparam int FL   [2]    = '{34, 20};
  localparam int SRES [2][2] = '{'{0, 1},  '{0, 0}};
  localparam int SST  [2][2] = '{'{0, 17}, '{0, 5}};
  localparam int SDU  [2][2] = '{'{1, 1},  '{2, 1}};
  localparam int LRES [2][2] = '{'{2, 2},  '{1, 0}};
  localparam int LST  [2][2] = '{'{1, 18}, '{2, 8}};
  localparam int LCN  [2][2] = '{'{8, 8},  '{1, 6}};
  localparam int LPE  [2][2] = '{'{2, 2},  '{3, 1}};
  localparam int LDU  [2][2] = '{'{2, 2},  '{1, 1}};

  logic [5:0] d_top;
  logic [4:0] a_top;
  logic [1:0] d_sg, a_sg, d_go, a_go, d_busy, a_busy, d_fire, a_fire;
  logic [7:0] d_iter, a_iter;
  logic [3:0] d_lat, a_lat;
  logic [2:0] d_rs, a_rs;
  logic [5:0] d_sel, a_sel;

  sched_loop_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .top_count(d_top), .sg_start(d_sg), .loop_go(d_go),
    .loop_busy(d_busy), .loop_fire(d_fire), .loop_iter(d_iter), .out_latch(d_lat),
    .res_start(d_rs), .res_sel(d_sel));

  sched_loop_ctrl #(
    .FRAME_LEN(20),
    .SG_RES('{0, 0}), .SG_START('{0, 5}), .SG_DUR('{2, 1}),
    .LP_RES('{1, 0}), .LP_START('{2, 8}), .LP_COUNT('{1, 6}),
    .LP_PERIOD('{3, 1}), .LP_DUR('{1, 1})
  ) u_dut_alt (
    .clk(clk), .rst_n(rst_n), .top_count(a_top), .sg_start(a_sg), .loop_go(a_go),
    .loop_busy(a_busy), .loop_fire(a_fire), .loop_iter(a_iter), .out_latch(a_lat),
    .res_start(a_rs), .res_sel(a_sel));

  int esel [2][3];

  task automatic chk(input string req, input string what, input int c, input int t,
                     input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cfg%0d t=%0d %s: actual %0d expected %0d", req, c, t, what, act, exp);
    end
  endtask

  task automatic model_cmp(input int c, input int t, input int top, input logic [1:0] sg,
                           input logic [1:0] go, input logic [1:0] busy, input logic [1:0] fire,
                           input logic [7:0] iter, input logic [3:0] lat,
                           input logic [2:0] rs, input logic [5:0] sel);
    int tt;
    bit us [4];
    tt = t % FL[c];
    chk("R2", "top_count", c, t, top, tt);
    for (int s = 0; s < 2; s++) begin
      us[s] = (tt == SST[c][s]);
      chk("R3", "sg_start", c, t, int'(sg[s]), int'(us[s]));
      chk("R7", "one-off latch", c, t, int'(lat[s]), int'(tt == SST[c][s] + SDU[c][s] - 1));
    end
    for (int l = 0; l < 2; l++) begin
      int rel;
      bit b;
      rel = tt - LST[c][l];
      b = (rel >= 0) && (rel < LCN[c][l] * LPE[c][l]);
      us[2+l] = b && (rel % LPE[c][l] == 0);
      chk("R4", "loop_go", c, t, int'(go[l]), int'(rel == 0));
      chk("R4", "loop_busy", c, t, int'(busy[l]), int'(b));
      chk(c == 0 ? "R5" : "R10", "loop_fire", c, t, int'(fire[l]), int'(us[2+l]));
      if (b) chk("R6", "loop_iter", c, t, int'(iter[l*4 +: 4]), rel / LPE[c][l]);
      chk("R7", "loop latch", c, t, int'(lat[2+l]), int'(b && (rel % LPE[c][l] == LDU[c][l] - 1)));
    end
    for (int r = 0; r < 3; r++) begin
      bit hit;
      hit = 1'b0;
      for (int u = 0; u < 4; u++) begin
        int ur;
        if (u < 2) ur = SRES[c][u];
        else       ur = LRES[c][u-2];
        if (us[u] && ur == r) begin
          hit = 1'b1;
          esel[c][r] = u;
        end
      end
      chk("R8", "res_start", c, t, int'(rs[r]), int'(hit));
      chk(c == 0 ? "R9" : "R10", "res_sel", c, t, int'(sel[r*2 +: 2]), esel[c][r]);
    end
  endtask

  task automatic reset_check();
    chk("R1", "top_count in reset", 0, -1, int'(d_top), 0);
    chk("R1", "loop_busy in reset", 0, -1, int'(d_busy), 0);
    chk("R1", "res_sel in reset", 0, -1, int'(d_sel), 0);
    chk("R1", "top_count in reset", 1, -1, int'(a_top), 0);
    chk("R1", "loop_busy in reset", 1, -1, int'(a_busy), 0);
    chk("R1", "res_sel in reset", 1, -1, int'(a_sel), 0);
  endtask

  task automatic run_cycles(input int n);
    for (int c = 0; c < 2; c++)
      for (int r = 0; r < 3; r++) esel[c][r] = 0;
    for (int t = 0; t < n; t++) begin
      model_cmp(0, t, int'(d_top), d_sg, d_go, d_busy, d_fire, d_iter, d_lat, d_rs, d_sel);
      model_cmp(1, t, int'(a_top), a_sg, a_go, a_busy, a_fire, a_iter, a_lat, a_rs, a_sel);
      @(negedge clk);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    reset_check();
    rst_n = 1'b1;
    run_cycles(110);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    reset_check();
    rst_n = 1'b1;
    run_cycles(45);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule